// File: doc/BRIEF.md
# Dual-Rate Configurable Serializer/Deserializer Pair

This block pairs a transmit serializer with a receive deserializer for a pad-side I/O slot. The transmit half takes one parallel word per frame and sends it out least significant bit first. The receive half gathers serial beats into parallel words, with the first beat received landing in bit 0. Each half runs at single rate (one bit per serial cycle) or at double rate (two bits per serial cycle, one for each clock edge). Each cell holds 2 or 6 bits. When cascaded, a second cell joins the first through a short shift link, which doubles the word to 4 or 12 bits.

Everything runs on the fast serial clock. The slower parallel rhythm comes from a frame state machine in each half. It has three states: `FR_IDLE` (disabled), `FR_LOAD` (first beat of a frame, where the transmit word is taken) and `FR_SHIFT` (the remaining beats). The transitions are:
- `FR_IDLE -> FR_LOAD` when the enable is seen high.
- `FR_LOAD -> FR_SHIFT` when more than one beat is left.
- `FR_LOAD -> FR_LOAD` or `FR_SHIFT -> FR_LOAD` on the frame's last beat.
- `FR_SHIFT -> FR_SHIFT` while beats remain.
- Any state `-> FR_IDLE` when the enable is seen low.

On the double-rate path, bit 0 of each pad pair is the rising-edge bit and bit 1 is the falling-edge bit. The two-edge muxing and sampling happen in the pad buffer, outside this block. A register sits directly at each pad, on both transmit and receive. Configuration is changed only while both enables are low.

Top module: `sd_serdes_pair`

## Requirements
- R1: While `rst` is high at a clock edge, every register is cleared. After that edge `tx_pad`=0, `tx_req`=0, `rx_valid`=0 and `rx_word`=0.
- R2: `cfg_wide`=0 gives 2 bits per cell and `cfg_wide`=1 gives 6. `cfg_cascade`=1 doubles the word length L. A frame lasts N=L serial cycles at single rate and N=L/2 cycles at double rate.
- R3: Single rate (`cfg_ddr`=0). Let E0 be the edge where `tx_en` is first seen high. Bit b of word f is on `tx_pad[0]` in the cycle after edge E(2+f·N+b), and `tx_pad[1]` is 0.
- R4: Double rate (`cfg_ddr`=1). In the cycle after edge E(2+f·N+b), `tx_pad[0]` carries bit 2b and `tx_pad[1]` carries bit 2b+1 of word f.
- R5: `tx_req` is high in the cycle after E(f·N) and low otherwise. Word f is sampled from `tx_word` at the edge that ends that cycle. Frames follow back to back with no gap, including when N=1.
- R6: Single rate receive. Let E0 be the edge where `rx_en` is first seen high. Beat j is the value of `rx_pad[0]` sampled at edge E(j), and `rx_pad[1]` is ignored. Word f holds beats f·N to f·N+N−1, with the earliest beat in bit 0.
- R7: Double rate receive. Each edge E(j) samples a pair. `rx_pad[0]` becomes the lower bit and `rx_pad[1]` the upper bit of that pair in the word.
- R8: Word f appears on `rx_word` with a one-cycle `rx_valid` pulse in the cycle after edge E((f+1)·N+1). Bits of `rx_word` at and above L are 0.
- R9: In cascade, the second cell carries word bits L/2 to L−1 and joins the first cell's shift chain. The result equals a single chain of length L.
- R10: An enable seen low returns its half to `FR_IDLE`. The transmit pad then drains the remaining bits and stays 0. The receiver raises no further `rx_valid` after its last completed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_ddr | input | 1 | 1 = two bits per serial cycle |
| cfg_wide | input | 1 | 1 = 6 bits per cell, 0 = 2 bits |
| cfg_cascade | input | 1 | 1 = join the second cell's chain |
| tx_en | input | 1 | Transmit frame enable |
| tx_word | input | 2·WIDE_W | Parallel word to send, taken when `tx_req` is high |
| tx_req | output | 1 | High in the cycle before the word is sampled |
| tx_pad | output | 2 | Registered serial output pair |
| rx_en | input | 1 | Receive frame enable |
| rx_pad | input | 2 | Serial input pair |
| rx_word | output | 2·WIDE_W | Assembled parallel word |
| rx_valid | output | 1 | One-cycle pulse marking a new `rx_word` |

## Verification
The hardest thing to reach from the ports is exact word alignment when rate, cell width and cascade all change how bits move between the two cells. This is worst in the one-beat frame, where `FR_LOAD` repeats every cycle. It is also hard in double-rate cascade, where the pair crosses the cell link in a single step. The stimulus enables each half at a known edge and drives a precomputed beat stream one pad pair per cycle. Expected pad values and word boundaries are derived from the edge count since enable, so one misplaced pipeline stage or a swapped pair shows up at once. Single-rate receive tests drive the unused pad bit with the complement of the data bit, which makes any leak of it visible.

// File: rtl/sd_pkg.sv
package sd_pkg;

    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_LOAD  = 2'd1,
        FR_SHIFT = 2'd2
    } frame_state_e;

    function automatic int word_bits(input logic wide, input logic casc,
                                     input int narrow_w, input int wide_w);
        int per_cell;
        per_cell = wide ? wide_w : narrow_w;
        return casc ? 2 * per_cell : per_cell;
    endfunction

    function automatic int beats_per_word(input int bits, input logic ddr);
        return ddr ? bits / 2 : bits;
    endfunction

endpackage

// File: rtl/sd_frame_fsm.sv
module sd_frame_fsm
    import sd_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] beats,
    output logic             in_frame,
    output logic             first,
    output logic             last
);

    frame_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             wrap;

    assign wrap = (cnt_q == beats - CNT_W'(1));

    always_comb begin
        state_d = FR_IDLE;
        unique case (state_q)
            FR_IDLE:  state_d = en ? FR_LOAD : FR_IDLE;
            FR_LOAD,
            FR_SHIFT: begin
                if (!en)       state_d = FR_IDLE;
                else if (wrap) state_d = FR_LOAD;
                else           state_d = FR_SHIFT;
            end
            default:  state_d = FR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_d == FR_SHIFT) ? cnt_q + CNT_W'(1) : '0;
        end
    end

    always_comb begin
        in_frame = 1'b0;
        first    = 1'b0;
        last     = 1'b0;
        unique case (state_q)
            FR_IDLE:  ;
            FR_LOAD:  begin in_frame = 1'b1; first = 1'b1; last = wrap; end
            FR_SHIFT: begin in_frame = 1'b1; last = wrap; end
            default:  ;
        endcase
    end

    AST_WRAP_RELOADS: assert property (@(posedge clk) disable iff (rst)
        (in_frame && last && en) |=> first);               // R5
    AST_DISABLE_IDLES: assert property (@(posedge clk) disable iff (rst)
        !en |=> !in_frame);                                // R10

endmodule

// File: rtl/sd_shift_cell.sv
module sd_shift_cell #(
    parameter int WIDE_W   = 6,
    parameter int NARROW_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic              len_wide,
    input  logic              step2,
    input  logic [WIDE_W-1:0] load_val,
    input  logic [1:0]        link_in,
    output logic [WIDE_W-1:0] q
);

    localparam int EXT_W = WIDE_W + 2;

    logic [WIDE_W-1:0] q_r, q_nx, len_mask;
    logic [EXT_W-1:0]  ext, ext_sh;
    int                cur_len;

    always_comb begin
        cur_len  = len_wide ? WIDE_W : NARROW_W;
        len_mask = WIDE_W'((EXT_W'(1) << cur_len) - EXT_W'(1));
        ext      = ({2'b00, q_r} & {2'b00, len_mask})
                 | ({{WIDE_W{1'b0}}, link_in} << cur_len);
        ext_sh   = step2 ? (ext >> 2) : (ext >> 1);
        q_nx     = q_r;
        if (load)       q_nx = load_val & len_mask;
        else if (shift) q_nx = ext_sh[WIDE_W-1:0] & len_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) q_r <= '0;
        else     q_r <= q_nx;
    end

    assign q = q_r;

    AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ((load || shift) && !len_wide) |=> (q_r[WIDE_W-1:NARROW_W] == '0)); // R2

endmodule

// File: rtl/sd_serdes_pair.sv
module sd_serdes_pair
    import sd_pkg::*;
#(
    parameter int WIDE_W   = 6,
    parameter int NARROW_W = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_ddr,
    input  logic                cfg_wide,
    input  logic                cfg_cascade,
    input  logic                tx_en,
    input  logic [2*WIDE_W-1:0] tx_word,
    output logic                tx_req,
    output logic [1:0]          tx_pad,
    input  logic                rx_en,
    input  logic [1:0]          rx_pad,
    output logic [2*WIDE_W-1:0] rx_word,
    output logic                rx_valid
);

    localparam int WORD_W = 2 * WIDE_W;
    localparam int CNT_W  = $clog2(WORD_W + 1);

    int               bits_i, cell_len;
    logic [CNT_W-1:0] beats;

    always_comb begin
        bits_i   = word_bits(cfg_wide, cfg_cascade, NARROW_W, WIDE_W);
        beats    = CNT_W'(beats_per_word(bits_i, cfg_ddr));
        cell_len = cfg_wide ? WIDE_W : NARROW_W;
    end

    // ---------------- transmit half ----------------
    logic              tx_in_frame, tx_first, tx_last;
    logic [WIDE_W-1:0] tm_q, ts_q, tx_slave_val;
    logic [1:0]        tm_link;
    logic [1:0]        tx_pad_r;

    sd_frame_fsm #(.CNT_W(CNT_W)) u_tx_fsm (
        .clk(clk), .rst(rst), .en(tx_en), .beats(beats),
        .in_frame(tx_in_frame), .first(tx_first), .last(tx_last)
    );

    assign tx_slave_val = WIDE_W'(tx_word >> cell_len);
    assign tm_link      = cfg_cascade ? ts_q[1:0] : 2'b00;

    sd_shift_cell #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_tx_master (
        .clk(clk), .rst(rst), .load(tx_first), .shift(1'b1),
        .len_wide(cfg_wide), .step2(cfg_ddr),
        .load_val(tx_word[WIDE_W-1:0]), .link_in(tm_link), .q(tm_q)
    );

    sd_shift_cell #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_tx_slave (
        .clk(clk), .rst(rst), .load(tx_first && cfg_cascade), .shift(1'b1),
        .len_wide(cfg_wide), .step2(cfg_ddr),
        .load_val(tx_slave_val), .link_in(2'b00), .q(ts_q)
    );

    always_ff @(posedge clk) begin
        if (rst)          tx_pad_r <= 2'b00;
        else if (cfg_ddr) tx_pad_r <= tm_q[1:0];
        else              tx_pad_r <= {1'b0, tm_q[0]};
    end

    assign tx_pad = tx_pad_r;
    assign tx_req = tx_first;

    // ---------------- receive half ----------------
    logic              rx_in_frame, rx_first, rx_last, rx_last_d;
    logic [1:0]        rx_pad_q, rm_link;
    logic [WIDE_W-1:0] rm_q, rs_q;
    logic [WORD_W-1:0] rx_assembled, rx_word_r;
    logic              rx_valid_r;

    sd_frame_fsm #(.CNT_W(CNT_W)) u_rx_fsm (
        .clk(clk), .rst(rst), .en(rx_en), .beats(beats),
        .in_frame(rx_in_frame), .first(rx_first), .last(rx_last)
    );

    always_ff @(posedge clk) begin
        if (rst)          rx_pad_q <= 2'b00;
        else if (cfg_ddr) rx_pad_q <= rx_pad;
        else              rx_pad_q <= {1'b0, rx_pad[0]};
    end

    assign rm_link = cfg_cascade ? rs_q[1:0] : rx_pad_q;

    sd_shift_cell #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_rx_master (
        .clk(clk), .rst(rst), .load(1'b0), .shift(rx_in_frame),
        .len_wide(cfg_wide), .step2(cfg_ddr),
        .load_val('0), .link_in(rm_link), .q(rm_q)
    );

    sd_shift_cell #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_rx_slave (
        .clk(clk), .rst(rst), .load(1'b0), .shift(rx_in_frame && cfg_cascade),
        .len_wide(cfg_wide), .step2(cfg_ddr),
        .load_val('0), .link_in(rx_pad_q), .q(rs_q)
    );

    assign rx_assembled = WORD_W'(rm_q)
                        | (cfg_cascade ? (WORD_W'(rs_q) << cell_len) : '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_last_d  <= 1'b0;
            rx_valid_r <= 1'b0;
            rx_word_r  <= '0;
        end else begin
            rx_last_d  <= rx_last;
            rx_valid_r <= rx_last_d;
            if (rx_last_d) rx_word_r <= rx_assembled;
        end
    end

    assign rx_word  = rx_word_r;
    assign rx_valid = rx_valid_r;

    // ---------------- checks ----------------
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (tx_pad == 2'b00 && !rx_valid));                 // R1
    AST_TX_REQ_CADENCE: assert property (@(posedge clk) disable iff (rst)
        (tx_last && tx_en) |=> tx_req);                                 // R5
    AST_RX_LAST_TO_VALID: assert property (@(posedge clk) disable iff (rst)
        rx_last |=> ##1 rx_valid);                                      // R8
    AST_RX_NEXT_FRAME: assert property (@(posedge clk) disable iff (rst)
        (rx_last && rx_en) |=> rx_first);                               // R6
    AST_VALID_GAP: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && beats != CNT_W'(1)) |=> !rx_valid);                // R8
    AST_TX_DRAINS: assert property (@(posedge clk) disable iff (rst)
        (tx_pad != 2'b00) |-> $past(|{tm_q, ts_q}));                    // R10

endmodule

// File: tb/test_sd_serdes_pair.sv
module test_sd_serdes_pair;

    localparam int WW = 6;
    localparam int WD = 2 * WW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_ddr = 1'b0, cfg_wide = 1'b0, cfg_cascade = 1'b0;
    logic          tx_en = 1'b0, rx_en = 1'b0;
    logic [WD-1:0] tx_word = '0;
    logic          tx_req, rx_valid;
    logic [1:0]    tx_pad;
    logic [1:0]    rx_pad = 2'b00;
    logic [WD-1:0] rx_word;

    int total = 0;
    int bad   = 0;

    logic [WD-1:0] words [0:7];
    int            cur_n;
    logic          cur_ddr;

    always #5 clk = ~clk;

    sd_serdes_pair #(.WIDE_W(WW), .NARROW_W(2)) i_sd_serdes_pair (
        .clk(clk), .rst(rst), .cfg_ddr(cfg_ddr), .cfg_wide(cfg_wide),
        .cfg_cascade(cfg_cascade), .tx_en(tx_en), .tx_word(tx_word),
        .tx_req(tx_req), .tx_pad(tx_pad), .rx_en(rx_en), .rx_pad(rx_pad),
        .rx_word(rx_word), .rx_valid(rx_valid)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic setup(input logic ddr, input logic wide, input logic casc, input int seed);
        int len;
        len     = (wide ? 6 : 2) * (casc ? 2 : 1);
        cur_n   = ddr ? len / 2 : len;
        cur_ddr = ddr;
        for (int f = 0; f < 8; f++)
            words[f] = WD'((seed * 13 + f * 'h9A5 + f * f * 7) & ((1 << len) - 1));
        cfg_ddr = ddr; cfg_wide = wide; cfg_cascade = casc;
    endtask

    function automatic logic [1:0] beat_of(input int j);
        int f, b;
        logic [WD-1:0] w;
        f = j / cur_n; b = j % cur_n; w = words[f];
        if (cur_ddr) return {w[2*b+1], w[2*b]};
        return {1'b0, w[b]};
    endfunction

    // R1
    task automatic test_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(tx_pad == 2'b00, "R1 tx_pad", int'(tx_pad), 0);
        chk(!tx_req, "R1 tx_req", int'(tx_req), 0);
        chk(!rx_valid, "R1 rx_valid", int'(rx_valid), 0);
        chk(rx_word == '0, "R1 rx_word", int'(rx_word), 0);
    endtask

    // R2 R3 R4 R5 R9 R10
    task automatic test_tx(input logic ddr, input logic wide, input logic casc,
                           input int nf, input int seed);
        logic [1:0] exp;
        setup(ddr, wide, casc, seed);
        tx_en = 1'b1;
        for (int k = 0; k <= nf * cur_n + 1; k++) begin
            @(posedge clk);
            @(negedge clk);
            chk(tx_req == (k % cur_n == 0), "R5 tx_req cadence", int'(tx_req), int'(k % cur_n == 0));
            if (k % cur_n == 0) tx_word = words[k / cur_n];
            if (k >= 2 && (k - 2) < nf * cur_n) exp = beat_of(k - 2);
            else                                exp = 2'b00;
            if (k < 2 || (k - 2) < nf * cur_n)
                chk(tx_pad == exp, ddr ? "R4 R2 R9 tx_pad ddr" : "R3 R2 R9 tx_pad sdr",
                    int'(tx_pad), int'(exp));
        end
        tx_en = 1'b0;
        repeat (20) @(negedge clk);
        chk(tx_pad == 2'b00, "R10 tx_pad drained", int'(tx_pad), 0);
        chk(!tx_req, "R10 tx_req idle", int'(tx_req), 0);
    endtask

    // R2 R6 R7 R8 R9 R10
    task automatic test_rx(input logic ddr, input logic wide, input logic casc,
                           input int nf, input int seed);
        logic ev;
        logic [1:0] bt;
        setup(ddr, wide, casc, seed);
        rx_en = 1'b1;
        bt = beat_of(0);
        rx_pad = ddr ? bt : {~bt[0], bt[0]};
        for (int k = 0; k <= nf * cur_n + 1; k++) begin
            @(posedge clk);
            @(negedge clk);
            ev = (k >= cur_n + 1) && ((k - 1) % cur_n == 0);
            chk(rx_valid == ev, "R8 rx_valid timing", int'(rx_valid), int'(ev));
            if (ev)
                chk(rx_word == words[(k - 1) / cur_n - 1],
                    ddr ? "R7 R9 rx_word ddr" : "R6 R9 rx_word sdr",
                    int'(rx_word), int'(words[(k - 1) / cur_n - 1]));
            bt = beat_of(k + 1);
            rx_pad = ddr ? bt : {~bt[0], bt[0]};
        end
        rx_en = 1'b0;
        repeat (2) @(negedge clk);
        for (int k = 0; k < 2 * cur_n + 4; k++) begin
            @(negedge clk);
            chk(!rx_valid, "R10 rx quiet after disable", int'(rx_valid), 0);
        end
    endtask

    initial begin
        #(200000 * 10);
        bad++;
        $display("FAIL watchdog expired total=%0d", total);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        test_reset();
        test_tx(1'b0, 1'b0, 1'b0, 4, 3);
        test_tx(1'b0, 1'b1, 1'b0, 3, 5);
        test_tx(1'b1, 1'b1, 1'b0, 4, 7);
        test_tx(1'b1, 1'b0, 1'b0, 6, 11);
        test_tx(1'b0, 1'b1, 1'b1, 3, 17);
        test_tx(1'b1, 1'b0, 1'b1, 4, 19);
        test_tx(1'b1, 1'b1, 1'b1, 3, 23);
        test_rx(1'b0, 1'b0, 1'b0, 4, 29);
        test_rx(1'b0, 1'b1, 1'b0, 3, 31);
        test_rx(1'b1, 1'b1, 1'b0, 4, 37);
        test_rx(1'b1, 1'b0, 1'b0, 6, 41);
        test_rx(1'b0, 1'b1, 1'b1, 3, 43);
        test_rx(1'b1, 1'b0, 1'b1, 4, 47);
        test_rx(1'b1, 1'b1, 1'b1, 3, 53);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule